// File: doc/BRIEF.md
# Channel-Access and Retransmit Controller for Frame Transmission

This block sequences the sending of one stored frame over a shared radio channel. A start request begins a transaction. In collision-avoidance mode the controller waits a random backoff, asks an external detector whether the channel is clear, and repeats with a growing backoff window while the channel stays busy. In listen-first mode it skips the backoff and keeps polling the detector until the channel is free. Once the channel is clear it starts the transmitter and tells it whether to append a frame check sequence. It then waits for an acknowledgement and, if the acknowledgement timer expires, starts the whole access procedure again for another frame attempt.

Each transaction that terminates ends with a single-cycle end pulse and a 3-bit result code held on a status output. The backoff draw comes from an 11-bit maximal-length shift register that software seeds through a load strobe. The detector, the transmitter, the acknowledgement timer and the frame store sit outside this block and talk to it through request/done handshakes and single-cycle event inputs.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After reset `busy`, `cca_req`, `tx_start`, `tx_append_fcs` and `end_pulse` are 0 and `result` reads 0.
- R2: A start accepted while idle raises `busy` and sets `result` to 7 (pending) until the end pulse, at which point `result` carries the final code.
- R3: In collision-avoidance mode (`cfg_lbt`=0) with a channel that reports busy on every assessment, exactly `cfg_csma_retries`+1 single-cycle `cca_req` pulses are issued, no `tx_start` is issued, and the transaction ends with result 3 (channel access failure).
- R4: A clear assessment leads to exactly one single-cycle `tx_start` pulse; `tx_append_fcs` is 1 during that pulse if and only if `cfg_auto_fcs` was 1 at start.
- R5: An `ack_rx` event after `tx_done` ends the transaction with result 0 (success).
- R6: Each `ack_timeout` event causes a new frame attempt with a fresh channel-access count and backoff window, up to `cfg_frame_retries` further attempts; when the last attempt also times out the transaction ends with result 5 (no acknowledgement).
- R7: In listen-first mode (`cfg_lbt`=1) a busy channel never ends the transaction; assessments repeat without limit and `cfg_csma_retries` has no effect.
- R8: In collision-avoidance mode the first `cca_req` of an attempt comes within (2^BE−1)·`UNIT_CYCLES`+3 clock cycles after the start was sampled, where BE is the minimum exponent; with both exponents 0 it comes exactly 2 cycles after the start edge.
- R9: `end_pulse` lasts one cycle, and `result` then stays unchanged while the block is idle.
- R10: In listen-first mode the backoff exponents are ignored: the first `cca_req` comes 1 cycle after the start edge even with both exponents at 8.
- R11: A start request while `busy` is 1 is ignored: the running transaction's number of assessments and its result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_auto_fcs | input | 1 | Ask the transmitter to append the FCS |
| cfg_frame_retries | input | 4 | Further frame attempts after an acknowledgement timeout (0..15) |
| cfg_lbt | input | 1 | 1 selects listen-first mode, 0 collision-avoidance mode |
| cfg_csma_retries | input | 3 | Further channel assessments after a busy result (0..7) |
| cfg_min_be | input | 4 | Minimum backoff exponent |
| cfg_max_be | input | 4 | Maximum backoff exponent |
| seed_hi | input | 3 | Upper 3 bits of the backoff generator seed |
| seed_lo | input | 8 | Lower 8 bits of the backoff generator seed |
| seed_load | input | 1 | Strobe loading the seed into the generator |
| start | input | 1 | Begin a transaction (single-cycle) |
| cca_req | output | 1 | Request one channel assessment (single-cycle) |
| cca_done | input | 1 | Assessment finished (single-cycle) |
| cca_busy | input | 1 | Assessment outcome, valid with `cca_done` |
| tx_start | output | 1 | Start transmitting the stored frame (single-cycle) |
| tx_append_fcs | output | 1 | Valid with `tx_start`: compute and append the FCS |
| tx_done | input | 1 | Transmission finished (single-cycle) |
| ack_rx | input | 1 | Acknowledgement received (single-cycle) |
| ack_timeout | input | 1 | Acknowledgement wait expired (single-cycle) |
| end_pulse | output | 1 | Transaction finished (single-cycle) |
| result | output | 3 | 0 success, 3 channel access failure, 5 no acknowledgement, 7 pending |
| busy | output | 1 | Transaction in progress |

## Verification
The hardest situation to reach is a frame retry whose new attempt itself meets a busy channel: it only shows that the channel-access count is restarted per attempt if both the acknowledgement path and the assessment path fail in the same transaction. The bench's responder reloads a per-attempt number of busy answers every time it issues an acknowledgement timeout, so with a retry limit of one, every attempt needs its second assessment, and a count carried over between attempts would end the transaction early with a channel-access failure. The endless busy channel of listen-first mode is reached by answering busy for thousands of cycles and then releasing the channel to let the transaction finish.

// File: rtl/csma_pkg.sv
// Shared types and result codes for the channel-access transmit controller.
// Assumes: result codes are 3 bits wide and decoded by software as listed.
package csma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BACKOFF,
        S_CCA_REQ,
        S_CCA_WAIT,
        S_TX_REQ,
        S_TX_WAIT,
        S_ACK_WAIT,
        S_FINISH
    } ctrl_state_t;

    localparam logic [2:0] RES_OK        = 3'd0;
    localparam logic [2:0] RES_CHAN_FAIL = 3'd3;
    localparam logic [2:0] RES_NO_ACK    = 3'd5;
    localparam logic [2:0] RES_PENDING   = 3'd7;

endpackage

// File: rtl/csma_lfsr.sv
// Backoff random source: maximal-length Fibonacci shift register.
// Advances one step per draw. A seed of all zeros would lock the register,
// so it is replaced by a fixed nonzero value.
// Assumes: W = 11 with taps at bits 10 and 8 (polynomial x^11 + x^9 + 1).
module csma_lfsr #(
    parameter int W      = 11,
    parameter int TAP_HI = W - 1,
    parameter int TAP_LO = W - 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] seed,
    input  logic         step,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] SAFE_SEED = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sr_q;
    logic         fb;

    // Feedback bit from the two taps.
    always_comb fb = sr_q[TAP_HI] ^ sr_q[TAP_LO];

    // Seed load has priority over stepping; zero seed is substituted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= SAFE_SEED;
        end else if (load) begin
            sr_q <= (seed == '0) ? SAFE_SEED : seed;
        end else if (step) begin
            sr_q <= {sr_q[W-2:0], fb};
        end
    end

    assign value = sr_q;

endmodule

// File: rtl/csma_backoff_timer.sv
// Backoff wait timer: counts a loaded number of unit periods, each
// UNIT_CYCLES clocks long. `expired` is high whenever no units remain.
// Assumes: a load while counting restarts the wait.
module csma_backoff_timer #(
    parameter int UNIT_CYCLES = 4,
    parameter int UNITS_W     = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [UNITS_W-1:0] units,
    output logic               expired
);

    localparam int TICK_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(UNIT_CYCLES - 1);

    logic [UNITS_W-1:0] left_q;
    logic [TICK_W-1:0]  tick_q;

    // Count ticks inside a unit and units down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            tick_q <= '0;
        end else if (load) begin
            left_q <= units;
            tick_q <= '0;
        end else if (left_q != '0) begin
            if (tick_q == TICK_LAST) begin
                tick_q <= '0;
                left_q <= left_q - 1'b1;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    assign expired = (left_q == '0);

endmodule

// File: rtl/csma_ctrl_fsm.sv
// Transaction sequencer: backoff, channel assessment, transmit, ack wait,
// frame and access retries, result reporting. Configuration is captured at
// start. Asks for a backoff draw (`draw`) with the exponent to use.
// Assumes: cca_done arrives no earlier than the cycle after cca_req, and
// tx_done / ack events only in the states waiting for them.
module csma_ctrl_fsm
    import csma_pkg::*;
#(
    parameter int BE_W    = 4,
    parameter int BE_CAP  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_auto_fcs,
    input  logic [3:0]      cfg_frame_retries,
    input  logic            cfg_lbt,
    input  logic [2:0]      cfg_csma_retries,
    input  logic [BE_W-1:0] cfg_min_be,
    input  logic [BE_W-1:0] cfg_max_be,
    input  logic            start,
    input  logic            cca_done,
    input  logic            cca_busy,
    input  logic            tx_done,
    input  logic            ack_rx,
    input  logic            ack_timeout,
    input  logic            backoff_expired,
    output logic            draw,
    output logic [BE_W-1:0] draw_be,
    output logic            cca_req,
    output logic            tx_start,
    output logic            tx_append_fcs,
    output logic            end_pulse,
    output logic [2:0]      result,
    output logic            busy
);

    localparam logic [BE_W-1:0] BE_LIM = BE_W'(BE_CAP);

    ctrl_state_t     state_q;
    logic [2:0]      csma_cnt_q, csma_lim_q;
    logic [3:0]      frame_cnt_q, frame_lim_q;
    logic [BE_W-1:0] be_q, min_be_q, max_be_q;
    logic            lbt_q, fcs_q;
    logic [2:0]      result_q;

    logic [BE_W-1:0] cfg_max_eff, cfg_min_eff, be_inc;
    logic            cca_busy_ev, cca_clear_ev, retry_access, access_fail;
    logic            frame_retry, frame_fail, start_ev;

    // Clamp configured exponents to the supported window and to each other.
    always_comb begin
        cfg_max_eff = (cfg_max_be > BE_LIM) ? BE_LIM : cfg_max_be;
        cfg_min_eff = (cfg_min_be > cfg_max_eff) ? cfg_max_eff : cfg_min_be;
        be_inc      = (be_q >= max_be_q) ? max_be_q : be_q + 1'b1;
    end

    // Decode the events that steer the sequence.
    always_comb begin
        start_ev     = (state_q == S_IDLE) && start;
        cca_busy_ev  = (state_q == S_CCA_WAIT) && cca_done && cca_busy;
        cca_clear_ev = (state_q == S_CCA_WAIT) && cca_done && !cca_busy;
        retry_access = cca_busy_ev && !lbt_q && (csma_cnt_q != csma_lim_q);
        access_fail  = cca_busy_ev && !lbt_q && (csma_cnt_q == csma_lim_q);
        frame_retry  = (state_q == S_ACK_WAIT) && !ack_rx && ack_timeout
                       && (frame_cnt_q != frame_lim_q);
        frame_fail   = (state_q == S_ACK_WAIT) && !ack_rx && ack_timeout
                       && (frame_cnt_q == frame_lim_q);
    end

    // Backoff draw request and the exponent that bounds it.
    always_comb begin
        draw    = (start_ev && !cfg_lbt) || retry_access || (frame_retry && !lbt_q);
        draw_be = start_ev    ? cfg_min_eff :
                  frame_retry ? min_be_q    : be_inc;
    end

    // Sequence state, counters and captured configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            csma_cnt_q  <= '0;
            csma_lim_q  <= '0;
            frame_cnt_q <= '0;
            frame_lim_q <= '0;
            be_q        <= '0;
            min_be_q    <= '0;
            max_be_q    <= '0;
            lbt_q       <= 1'b0;
            fcs_q       <= 1'b0;
            result_q    <= RES_OK;
        end else begin
            if (draw) be_q <= draw_be;
            unique case (state_q)
                S_IDLE: if (start) begin
                    csma_cnt_q  <= '0;
                    frame_cnt_q <= '0;
                    csma_lim_q  <= cfg_csma_retries;
                    frame_lim_q <= cfg_frame_retries;
                    min_be_q    <= cfg_min_eff;
                    max_be_q    <= cfg_max_eff;
                    lbt_q       <= cfg_lbt;
                    fcs_q       <= cfg_auto_fcs;
                    result_q    <= RES_PENDING;
                    state_q     <= cfg_lbt ? S_CCA_REQ : S_BACKOFF;
                end
                S_BACKOFF: if (backoff_expired) state_q <= S_CCA_REQ;
                S_CCA_REQ: state_q <= S_CCA_WAIT;
                S_CCA_WAIT: begin
                    if (cca_clear_ev) begin
                        state_q <= S_TX_REQ;
                    end else if (retry_access) begin
                        csma_cnt_q <= csma_cnt_q + 1'b1;
                        state_q    <= S_BACKOFF;
                    end else if (access_fail) begin
                        result_q <= RES_CHAN_FAIL;
                        state_q  <= S_FINISH;
                    end else if (cca_busy_ev) begin
                        state_q <= S_CCA_REQ;
                    end
                end
                S_TX_REQ: state_q <= S_TX_WAIT;
                S_TX_WAIT: if (tx_done) state_q <= S_ACK_WAIT;
                S_ACK_WAIT: begin
                    if (ack_rx) begin
                        result_q <= RES_OK;
                        state_q  <= S_FINISH;
                    end else if (frame_retry) begin
                        frame_cnt_q <= frame_cnt_q + 1'b1;
                        csma_cnt_q  <= '0;
                        state_q     <= lbt_q ? S_CCA_REQ : S_BACKOFF;
                    end else if (frame_fail) begin
                        result_q <= RES_NO_ACK;
                        state_q  <= S_FINISH;
                    end
                end
                S_FINISH: state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    // Handshake and status outputs decoded from the state.
    always_comb begin
        cca_req       = (state_q == S_CCA_REQ);
        tx_start      = (state_q == S_TX_REQ);
        tx_append_fcs = (state_q == S_TX_REQ) && fcs_q;
        end_pulse     = (state_q == S_FINISH);
        busy          = (state_q != S_IDLE);
        result        = result_q;
    end

endmodule

// File: rtl/csma_tx_ctrl.sv
// Top level of the channel-access transmit controller: joins the sequencer,
// the backoff random source and the backoff timer. The drawn unit count is
// the low BE bits of the random source.
// Assumes: UNITS_W >= BE_CAP so every exponent fits the timer.
module csma_tx_ctrl #(
    parameter int UNIT_CYCLES = 4,
    parameter int SEED_W      = 11,
    parameter int BE_CAP      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_auto_fcs,
    input  logic [3:0] cfg_frame_retries,
    input  logic       cfg_lbt,
    input  logic [2:0] cfg_csma_retries,
    input  logic [3:0] cfg_min_be,
    input  logic [3:0] cfg_max_be,
    input  logic [2:0] seed_hi,
    input  logic [7:0] seed_lo,
    input  logic       seed_load,
    input  logic       start,
    output logic       cca_req,
    input  logic       cca_done,
    input  logic       cca_busy,
    output logic       tx_start,
    output logic       tx_append_fcs,
    input  logic       tx_done,
    input  logic       ack_rx,
    input  logic       ack_timeout,
    output logic       end_pulse,
    output logic [2:0] result,
    output logic       busy
);

    localparam int BE_W    = 4;
    localparam int UNITS_W = BE_CAP;

    logic              draw, bo_expired;
    logic [BE_W-1:0]   draw_be;
    logic [SEED_W-1:0] rnd;
    logic [UNITS_W-1:0] units, mask;

    csma_ctrl_fsm #(.BE_W(BE_W), .BE_CAP(BE_CAP)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cfg_auto_fcs(cfg_auto_fcs), .cfg_frame_retries(cfg_frame_retries),
        .cfg_lbt(cfg_lbt), .cfg_csma_retries(cfg_csma_retries),
        .cfg_min_be(cfg_min_be), .cfg_max_be(cfg_max_be),
        .start(start), .cca_done(cca_done), .cca_busy(cca_busy),
        .tx_done(tx_done), .ack_rx(ack_rx), .ack_timeout(ack_timeout),
        .backoff_expired(bo_expired), .draw(draw), .draw_be(draw_be),
        .cca_req(cca_req), .tx_start(tx_start), .tx_append_fcs(tx_append_fcs),
        .end_pulse(end_pulse), .result(result), .busy(busy)
    );

    csma_lfsr #(.W(SEED_W)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(seed_load),
        .seed({seed_hi, seed_lo}), .step(draw), .value(rnd)
    );

    // Mask of BE low ones, one bit per possible exponent value.
    always_comb begin
        for (int i = 0; i < UNITS_W; i++) mask[i] = (BE_W'(i) < draw_be);
        units = rnd[UNITS_W-1:0] & mask;
    end

    csma_backoff_timer #(.UNIT_CYCLES(UNIT_CYCLES), .UNITS_W(UNITS_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(draw), .units(units), .expired(bo_expired)
    );

endmodule

// File: rtl/csma_tx_ctrl_chk.sv
// Protocol checker for the transmit controller, bound to the top module.
// Assumes: observes top-level ports only.
module csma_tx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cca_req,
    input logic       tx_start,
    input logic       tx_append_fcs,
    input logic       end_pulse,
    input logic [2:0] result,
    input logic       busy
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(cca_req || tx_start || end_pulse));

    p_pending_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !end_pulse) |-> (result == 3'd7));

    p_cca_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cca_req |=> !cca_req);

    p_fcs_with_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_append_fcs |-> tx_start);

    p_final_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |-> (result == 3'd0 || result == 3'd3 || result == 3'd5));

    p_end_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_pulse |=> (!end_pulse && !busy));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(result));

endmodule

bind csma_tx_ctrl csma_tx_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .cca_req(cca_req), .tx_start(tx_start),
    .tx_append_fcs(tx_append_fcs), .end_pulse(end_pulse),
    .result(result), .busy(busy)
);

// File: tb/csma_tx_ctrl_tb_top.sv
// Directed bench: a responder plays detector, transmitter and ack timer;
// one task per scenario configures it and checks the outcome.
module csma_tx_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_auto_fcs = 1'b0, cfg_lbt = 1'b0;
    logic [3:0] cfg_frame_retries = '0, cfg_min_be = '0, cfg_max_be = '0;
    logic [2:0] cfg_csma_retries = '0, seed_hi = '0;
    logic [7:0] seed_lo = '0;
    logic seed_load = 1'b0, start = 1'b0;
    logic cca_done = 1'b0, cca_busy = 1'b0, tx_done = 1'b0;
    logic ack_rx = 1'b0, ack_timeout = 1'b0;
    logic cca_req, tx_start, tx_append_fcs, end_pulse, busy;
    logic [2:0] result;

    int total = 0, bad = 0, cyc = 0;
    int cca_cnt = 0, tx_cnt = 0, end_cnt = 0, fcs_seen = 0, fcs_bad = 0;
    int first_cca = -1, t0 = 0;
    int busy_left = 0, busy_reload = 0, to_left = 0;
    bit busy_forever = 1'b0;
    logic [2:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    csma_tx_ctrl #(.UNIT_CYCLES(UNIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_auto_fcs(cfg_auto_fcs),
        .cfg_frame_retries(cfg_frame_retries), .cfg_lbt(cfg_lbt),
        .cfg_csma_retries(cfg_csma_retries), .cfg_min_be(cfg_min_be),
        .cfg_max_be(cfg_max_be), .seed_hi(seed_hi), .seed_lo(seed_lo),
        .seed_load(seed_load), .start(start), .cca_req(cca_req),
        .cca_done(cca_done), .cca_busy(cca_busy), .tx_start(tx_start),
        .tx_append_fcs(tx_append_fcs), .tx_done(tx_done), .ack_rx(ack_rx),
        .ack_timeout(ack_timeout), .end_pulse(end_pulse), .result(result),
        .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responder: answers assessments, transmissions and ack waits.
    initial begin
        forever begin
            @(negedge clk);
            cca_done = 0; cca_busy = 0; tx_done = 0; ack_rx = 0; ack_timeout = 0;
            if (end_pulse) begin
                end_cnt++;
                last_res = result;
            end
            if (cca_req) begin
                if (cca_cnt == 0) first_cca = cyc - t0;
                cca_cnt++;
                @(negedge clk);
                @(negedge clk);
                cca_done = 1;
                cca_busy = busy_forever || (busy_left > 0);
                if (busy_left > 0) busy_left--;
            end else if (tx_start) begin
                tx_cnt++;
                if (tx_append_fcs) fcs_seen++;
                if (tx_append_fcs != cfg_auto_fcs) fcs_bad++;
                repeat (2) @(negedge clk);
                tx_done = 1;
                @(negedge clk);
                tx_done = 0;
                repeat (3) @(negedge clk);
                if (to_left > 0) begin
                    to_left--;
                    busy_left = busy_reload;
                    ack_timeout = 1;
                end else begin
                    ack_rx = 1;
                end
            end
        end
    end

    task automatic launch(input bit lbt, input bit fcs, input int csma_lim,
                          input int frame_lim, input int minbe, input int maxbe,
                          input int busy_n, input int to_n);
        cfg_lbt = lbt; cfg_auto_fcs = fcs;
        cfg_csma_retries = 3'(csma_lim); cfg_frame_retries = 4'(frame_lim);
        cfg_min_be = 4'(minbe); cfg_max_be = 4'(maxbe);
        busy_left = busy_n; busy_reload = busy_n; to_left = to_n;
        cca_cnt = 0; tx_cnt = 0; end_cnt = 0; fcs_seen = 0; fcs_bad = 0;
        first_cca = -1;
        @(negedge clk);
        start = 1; t0 = cyc;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_end(input int limit);
        for (int n = 0; n < limit && end_cnt == 0; n++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(!busy && !cca_req && !tx_start && !tx_append_fcs && !end_pulse,
              "R1 outputs idle", busy, 0);
        check(result == 3'd0, "R1 result", result, 0);
    endtask

    task automatic t_success_fcs;
        launch(0, 1, 3, 0, 0, 0, 0, 0);
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(result == 3'd7, "R2 pending code", result, 7);
        wait_end(500);
        check(first_cca == 2, "R8 zero exponent cca delay", first_cca, 2);
        check(tx_cnt == 1 && fcs_seen == 1 && fcs_bad == 0, "R4 fcs flag set", fcs_seen, 1);
        check(end_cnt == 1 && last_res == 3'd0, "R5 success code", last_res, 0);
        repeat (10) @(negedge clk);
        check(end_cnt == 1 && !busy, "R9 single end pulse", end_cnt, 1);
        check(result == 3'd0, "R9 result held", result, 0);
    endtask

    task automatic t_no_fcs;
        launch(0, 0, 2, 0, 1, 2, 2, 0);
        wait_end(2000);
        check(tx_cnt == 1 && fcs_seen == 0 && fcs_bad == 0, "R4 fcs flag clear", fcs_seen, 0);
        check(cca_cnt == 3 && last_res == 3'd0, "R4 clear after two busy", cca_cnt, 3);
    endtask

    task automatic t_access_fail;
        launch(0, 0, 4, 0, 2, 3, 99, 0);
        repeat (10) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        wait_end(5000);
        check(cca_cnt == 5, "R3 assessment count", cca_cnt, 5);
        check(tx_cnt == 0, "R3 no transmit", tx_cnt, 0);
        check(end_cnt == 1 && last_res == 3'd3, "R3 access failure code", last_res, 3);
        check(cca_cnt == 5 && last_res == 3'd3, "R11 start while busy ignored", cca_cnt, 5);
    endtask

    task automatic t_frame_retry_ok;
        launch(0, 1, 1, 2, 0, 1, 1, 2);
        wait_end(5000);
        check(tx_cnt == 3 && cca_cnt == 6, "R6 fresh access count per attempt", cca_cnt, 6);
        check(last_res == 3'd0, "R6 success on last attempt", last_res, 0);
    endtask

    task automatic t_no_ack;
        launch(0, 0, 0, 3, 0, 0, 0, 99);
        wait_end(5000);
        check(tx_cnt == 4, "R6 attempts used", tx_cnt, 4);
        check(end_cnt == 1 && last_res == 3'd5, "R6 no-ack code", last_res, 5);
    endtask

    task automatic t_backoff_bound;
        for (int k = 0; k < 6; k++) begin
            launch(0, 0, 0, 0, 3, 3, 0, 0);
            wait_end(2000);
            check(first_cca >= 2 && first_cca <= 7*UNIT + 3, "R8 backoff bound",
                  first_cca, 7*UNIT + 3);
        end
    endtask

    task automatic t_lbt_busy;
        launch(1, 0, 0, 0, 8, 8, 10, 0);
        wait_end(5000);
        check(first_cca == 1, "R10 exponents ignored", first_cca, 1);
        check(cca_cnt == 11 && last_res == 3'd0, "R7 retry limit ignored", cca_cnt, 11);
        busy_forever = 1'b1;
        launch(1, 0, 0, 0, 0, 0, 0, 0);
        repeat (3000) @(negedge clk);
        check(end_cnt == 0 && busy, "R7 no end while busy", end_cnt, 0);
        check(cca_cnt > 100, "R7 keeps assessing", cca_cnt, 100);
        busy_forever = 1'b0;
        wait_end(500);
        check(end_cnt == 1 && last_res == 3'd0, "R7 finishes when clear", last_res, 0);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        seed_load = 1; seed_hi = 3'h0; seed_lo = 8'h00;
        @(negedge clk);
        seed_hi = 3'h5; seed_lo = 8'hA7;
        @(negedge clk);
        seed_load = 0;
        t_success_fcs();
        t_no_fcs();
        t_access_fail();
        t_frame_retry_ok();
        t_no_ack();
        t_backoff_bound();
        t_lbt_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule